// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It takes an instruction word from an external instruction memory at the address it presents, decodes it, reads two registers, runs the ALU, performs at most one data-memory access and updates the register file and the program counter at the next rising edge. The supported subset is register-to-register arithmetic and logic (add, subtract, and, or, signed set-less-than), load word, store word, branch-if-equal and an absolute jump.

Both memories sit outside the core. The instruction port and the data-memory read port are combinational: a word presented on the read-data input within the same cycle is used by that cycle's instruction. Data-memory writes are expected to be committed by the memory on the rising edge at which the core's write strobe is high. Exceptions, overflow traps, multiply/divide and floating point are not part of the block.

Top module: `sc_datapath_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter becomes 0 and all 32 registers are cleared; `dmem_we` stays low while `rst_n` is low.
- R2: Source register A is taken from instruction bits [25:21] and source register B from bits [20:16]; register-to-register instructions write the register in bits [15:11], loads write the register in bits [20:16].
- R3: Opcode 000000 selects a register-to-register operation by function code in bits [5:0]: 100000 add, 100010 subtract (A minus B), 100100 and, 100101 or, 101010 set-less-than (signed compare, result 1 or 0).
- R4: Opcode 100011 (load word) asserts `dmem_re`, drives `dmem_addr` with register A plus the sign-extended 16-bit immediate in bits [15:0], and writes `dmem_rdata` into the destination register.
- R5: Opcode 101011 (store word) asserts `dmem_we` for that cycle only, with `dmem_addr` equal to register A plus the sign-extended immediate and `dmem_wdata` equal to register B; `dmem_we` and `dmem_re` are never high together.
- R6: Opcode 000100 (branch-if-equal) sets the next PC to PC+4 plus the sign-extended immediate shifted left by 2 when register A equals register B, and to PC+4 otherwise; negative offsets branch backwards.
- R7: Opcode 000010 (jump) sets the next PC to bits [31:28] of PC+4 followed by instruction bits [25:0] and two zero bits.
- R8: Register 0 always reads as zero; any write addressed to it is discarded.
- R9: Any opcode other than the five above writes no register, does not assert `dmem_we`, and advances the PC by 4.
- R10: Every instruction that is not a taken branch or a jump advances the PC by exactly 4 at the next rising edge, one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_re | output | 1 | High while a load is being executed |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The hardest case to reach from the ports is the jump splice of the upper PC bits, because those bits are only non-zero once the program counter has crossed a 256 MB boundary. The stimulus jumps to the highest word address a 26-bit target can name, so that PC+4 of that instruction carries a 1 in bit 28, and a second jump placed there must keep that bit; the bench's small instruction array aliases on the low address bits so the far addresses still fetch real code. Register state is invisible at the ports, so every result, including the attempted write to register 0 and the undefined opcode, is stored to data memory and compared, while a behavioural instruction model checks the PC and memory strobes every cycle.

// File: rtl/sc_core_pkg.sv
// Package: shared constants and types of the single-cycle core.
// Assumes a fixed 32-bit instruction format with 6-bit opcode and function fields.
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int REG_AW = $clog2(NREG);

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // Operation class handed from the main decoder to the ALU controller.
    typedef enum logic [1:0] {
        ACLS_ADD   = 2'b00,
        ACLS_SUB   = 2'b01,
        ACLS_FUNCT = 2'b10,
        ACLS_RSVD  = 2'b11
    } alu_class_e;

    // Operation performed by the ALU.
    typedef enum logic [2:0] {
        AOP_ADD,
        AOP_SUB,
        AOP_AND,
        AOP_OR,
        AOP_SLT
    } alu_op_e;

    // Control word produced from the opcode alone.
    typedef struct packed {
        logic       dst_is_rd;
        logic       is_branch;
        logic       mem_rd;
        logic       wb_from_mem;
        alu_class_e alu_class;
        logic       mem_wr;
        logic       b_is_imm;
        logic       reg_wr;
        logic       is_jump;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
// Main decoder: turns the 6-bit opcode into the control word.
// Assumes nothing else influences control; unknown opcodes yield an all-zero word.
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Opcode lookup; default leaves every strobe inactive.
    always_comb begin
        ctrl = '0;
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_class = ACLS_FUNCT;
                ctrl.reg_wr    = 1'b1;
            end
            OP_LOAD: begin
                ctrl.mem_rd      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.alu_class   = ACLS_ADD;
                ctrl.b_is_imm    = 1'b1;
                ctrl.reg_wr      = 1'b1;
            end
            OP_STORE: begin
                ctrl.mem_wr    = 1'b1;
                ctrl.alu_class = ACLS_ADD;
                ctrl.b_is_imm  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = ACLS_SUB;
            end
            OP_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu_ctl.sv
// ALU controller: combines the decoder's operation class with the function field.
// Assumes unsupported function codes fall back to addition.
module sc_alu_ctl
    import sc_core_pkg::*;
(
    input  alu_class_e alu_class,
    input  logic [5:0] funct,
    output alu_op_e    alu_op
);

    // Select the ALU operation for this instruction.
    always_comb begin
        alu_op = AOP_ADD;
        case (alu_class)
            ACLS_ADD: alu_op = AOP_ADD;
            ACLS_SUB: alu_op = AOP_SUB;
            ACLS_FUNCT: begin
                case (funct)
                    FN_ADD:  alu_op = AOP_ADD;
                    FN_SUB:  alu_op = AOP_SUB;
                    FN_AND:  alu_op = AOP_AND;
                    FN_OR:   alu_op = AOP_OR;
                    FN_SLT:  alu_op = AOP_SLT;
                    default: alu_op = AOP_ADD;
                endcase
            end
            default: alu_op = AOP_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational read ports, one write port on the rising edge.
// Assumes entry 0 is hard zero; synchronous active-low reset clears every entry.
module sc_regfile #(
    parameter int N_ENTRIES = 32,
    parameter int WIDTH     = 32,
    localparam int AW       = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] regs_q [N_ENTRIES];

    // Clear on reset, otherwise commit a write to any entry but 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en && (wr_addr != '0)) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read of both ports.
    always_comb begin
        rd_data_a = regs_q[rd_addr_a];
        rd_data_b = regs_q[rd_addr_b];
    end

    // R8
    zero_reg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (regs_q[0] == '0));

endmodule

// File: rtl/sc_alu.sv
// ALU: add, subtract, and, or, signed set-less-than, plus a zero flag.
// Assumes two's complement operands; overflow is not reported.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] result,
    output logic             is_zero
);

    // Compute the result of the selected operation.
    always_comb begin
        case (op)
            AOP_ADD: result = op_a + op_b;
            AOP_SUB: result = op_a - op_b;
            AOP_AND: result = op_a & op_b;
            AOP_OR:  result = op_a | op_b;
            AOP_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            default: result = op_a + op_b;
        endcase
    end

    // Zero flag used by branch-if-equal.
    always_comb begin
        is_zero = (result == '0);
    end

endmodule

// File: rtl/sc_datapath_core.sv
// Single-cycle core top: field slicing, sign extension, write-back selection
// and next-PC formation around the decoder, ALU controller, register file and ALU.
// Assumes combinational instruction and data reads; data writes commit at the edge.
module sc_datapath_core
    import sc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            dmem_re,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int IMM_W = 16;

    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   pc_next;
    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   br_target;
    logic [XLEN-1:0]   jmp_target;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   wb_data;
    logic [REG_AW-1:0] wb_addr;
    logic              alu_zero;
    logic              take_branch;
    logic [5:0]        opcode;
    ctrl_t             ctrl;
    alu_op_e           alu_op;

    assign opcode = imem_rdata[31:26];

    sc_main_dec u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    sc_alu_ctl u_alu_ctl (
        .alu_class (ctrl.alu_class),
        .funct     (imem_rdata[5:0]),
        .alu_op    (alu_op)
    );

    sc_regfile #(
        .N_ENTRIES (NREG),
        .WIDTH     (XLEN)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (imem_rdata[25:21]),
        .rd_addr_b (imem_rdata[20:16]),
        .rd_data_a (rs_val),
        .rd_data_b (rt_val),
        .wr_en     (ctrl.reg_wr),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data)
    );

    sc_alu #(
        .WIDTH (XLEN)
    ) u_alu (
        .op_a    (rs_val),
        .op_b    (alu_b),
        .op      (alu_op),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    // Operand, immediate and write-back selection.
    always_comb begin
        imm_ext = {{(XLEN-IMM_W){imem_rdata[IMM_W-1]}}, imem_rdata[IMM_W-1:0]};
        alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;
        wb_addr = ctrl.dst_is_rd ? imem_rdata[15:11] : imem_rdata[20:16];
        wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;
    end

    // Next-PC formation: jump over taken branch over sequential.
    always_comb begin
        pc_plus4    = pc_q + XLEN'(4);
        br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        jmp_target  = {pc_plus4[XLEN-1:28], imem_rdata[25:0], 2'b00};
        take_branch = ctrl.is_branch && alu_zero;
        if (ctrl.is_jump) begin
            pc_next = jmp_target;
        end else if (take_branch) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // Memory port drive; the store strobe is held off during reset.
    always_comb begin
        imem_addr  = pc_q;
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.mem_wr && rst_n;
        dmem_re    = ctrl.mem_rd;
    end

    // R5
    store_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !dmem_re);

    // R10
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.is_jump && !(ctrl.is_branch && alu_zero)) |=> (pc_q == $past(pc_q) + 32'd4));

    // R6
    branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.is_jump && ctrl.is_branch && alu_zero)
        |=> (pc_q == $past(pc_q) + 32'd4 + {$past(imem_rdata[29:0]), 2'b00}
                     - {$past(imem_rdata[29:16]), 18'd0}
                     + {{14{$past(imem_rdata[15])}}, 18'd0}));

    // R7
    jump_splice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_jump |=> (pc_q[27:0] == {$past(imem_rdata[25:0]), 2'b00})
                      && (pc_q[31:28] == $past(pc_plus4[31:28])));

    // R9
    undefined_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OP_RTYPE && opcode != OP_LOAD && opcode != OP_STORE &&
         opcode != OP_BEQ && opcode != OP_JUMP) |-> (!ctrl.reg_wr && !dmem_we));

endmodule

// File: tb/sc_datapath_core_test.sv
// Bench: holds both memories, runs a program and compares the core with a
// behavioural instruction model on every cycle.
module sc_datapath_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 64;
    localparam int RUN_CYCLES = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    logic [31:0] imem [MEM_WORDS];
    logic [31:0] dmem [MEM_WORDS];

    logic [31:0] m_pc;
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [MEM_WORDS];
    string       pc_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_datapath_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: one instruction per call.
    task automatic model_step();
        logic [31:0] ins, a, b, sx, res;
        logic [5:0]  op, fn;
        int rs, rt, rd, dst;
        bit wr;
        ins = imem[m_pc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_reg[rs]; b = m_reg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        wr = 0; dst = 0; res = 0;
        pc_tag = "R10";
        if (op == 6'b000000) begin
            wr = 1; dst = rd;
            if (fn == 6'b100010) res = a - b;
            else if (fn == 6'b100100) res = a & b;
            else if (fn == 6'b100101) res = a | b;
            else if (fn == 6'b101010) res = ($signed(a) < $signed(b)) ? 1 : 0;
            else res = a + b;
            m_pc = m_pc + 4;
        end else if (op == 6'b100011) begin
            wr = 1; dst = rt; res = m_mem[(a + sx) >> 2 & 63];
            m_pc = m_pc + 4;
        end else if (op == 6'b101011) begin
            m_mem[(a + sx) >> 2 & 63] = b;
            m_pc = m_pc + 4;
        end else if (op == 6'b000100) begin
            pc_tag = "R6";
            m_pc = (a == b) ? m_pc + 4 + sx * 4 : m_pc + 4;
        end else if (op == 6'b000010) begin
            pc_tag = "R7";
            m_pc = ((m_pc + 4) & 32'hF000_0000) | (32'(ins[25:0]) * 4);
        end else begin
            pc_tag = "R9";
            m_pc = m_pc + 4;
        end
        if (wr && dst != 0) m_reg[dst] = res;
    endtask

    // Compare the ports with what the model expects of the current instruction.
    task automatic compare_cycle();
        logic [31:0] ins, a, b, sx;
        logic [5:0]  op;
        ins = imem[m_pc[7:2]];
        op = ins[31:26];
        a = m_reg[int'(ins[25:21])]; b = m_reg[int'(ins[20:16])];
        sx = {{16{ins[15]}}, ins[15:0]};
        chk(pc_tag, imem_addr, m_pc, "pc");
        if (op == 6'b101011) begin
            chk("R5", 32'(dmem_we), 1, "store strobe");
            chk("R5", dmem_addr, a + sx, "store address");
            chk("R5", dmem_wdata, b, "store data");
        end else if (op == 6'b100011) begin
            chk("R4", 32'(dmem_re), 1, "load strobe");
            chk("R4", dmem_addr, a + sx, "load address");
            chk("R4", 32'(dmem_we), 0, "no store on load");
        end else begin
            chk((op == 6'b000000 || op == 6'b000100 || op == 6'b000010) ? "R10" : "R9",
                32'(dmem_we), 0, "no store");
        end
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            imem[i] = enc_i(6'b000100, 0, 0, -1);
            dmem[i] = 0;
        end
        dmem[0] = 32'd5; dmem[1] = 32'hFFFF_FFFD; dmem[2] = 32'd40;
        dmem[3] = 32'd1; dmem[4] = 32'd3;
        imem[0]  = enc_i(6'b100011, 0, 1, 0);
        imem[1]  = enc_i(6'b100011, 0, 2, 4);
        imem[2]  = enc_i(6'b100011, 0, 9, 8);
        imem[3]  = enc_i(6'b100011, 0, 11, 12);
        imem[4]  = enc_i(6'b100011, 0, 12, 16);
        imem[5]  = enc_r(1, 2, 3, 6'b100000);
        imem[6]  = enc_r(1, 2, 4, 6'b100010);
        imem[7]  = enc_r(1, 2, 5, 6'b100100);
        imem[8]  = enc_r(1, 2, 6, 6'b100101);
        imem[9]  = enc_r(2, 1, 7, 6'b101010);
        imem[10] = enc_r(1, 2, 8, 6'b101010);
        imem[11] = enc_r(1, 1, 0, 6'b100000);
        imem[12] = enc_i(6'b101011, 0, 3, 20);
        imem[13] = enc_i(6'b101011, 9, 4, -4);
        imem[14] = enc_i(6'b101011, 0, 0, 24);
        imem[15] = enc_i(6'b000100, 1, 1, 2);
        imem[16] = enc_i(6'b101011, 0, 1, 28);
        imem[17] = enc_i(6'b101011, 0, 1, 28);
        imem[18] = enc_i(6'b000100, 1, 2, 5);
        imem[19] = enc_r(10, 11, 10, 6'b100000);
        imem[20] = enc_i(6'b000100, 10, 12, 1);
        imem[21] = enc_j(26'd19);
        imem[22] = enc_i(6'b101011, 0, 10, 32);
        imem[23] = enc_i(6'b111111, 1, 13, 7);
        imem[24] = enc_i(6'b101011, 0, 13, 40);
        imem[25] = enc_j(26'h3FF_FFFF);
        imem[26] = enc_i(6'b101011, 0, 7, 44);
        imem[27] = enc_i(6'b101011, 0, 8, 48);
        imem[28] = enc_i(6'b101011, 0, 5, 52);
        imem[29] = enc_i(6'b101011, 0, 6, 56);
        imem[30] = enc_i(6'b000100, 0, 0, -1);
        imem[63] = enc_j(26'd26);
        for (int i = 0; i < MEM_WORDS; i++) m_mem[i] = dmem[i];
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
        m_pc = 0;
        pc_tag = "R1";

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", imem_addr, 0, "pc in reset");
        chk("R1", 32'(dmem_we), 0, "store strobe in reset");
        rst_n = 1'b1;

        for (int c = 0; c < RUN_CYCLES; c++) begin
            compare_cycle();
            if (m_pc == 32'h0FFF_FFFC) chk("R7", imem_addr, 32'h0FFF_FFFC, "far jump target");
            if (m_pc == 32'h1000_0068) chk("R7", imem_addr, 32'h1000_0068, "upper bits spliced");
            model_step();
            @(negedge clk);
        end

        chk("R2", dmem[5], 32'd2, "add result via rd field");
        chk("R3", dmem[9], 32'd8, "sub result, negative offset store");
        chk("R8", dmem[6], 32'd0, "register 0 after write attempt");
        chk("R6", dmem[7], 32'd0, "skipped store by taken branch");
        chk("R6", dmem[8], 32'd3, "loop count via backward jump");
        chk("R9", dmem[10], 32'd0, "undefined opcode wrote nothing");
        chk("R3", dmem[11], 32'd1, "slt negative < positive");
        chk("R3", dmem[12], 32'd0, "slt positive < negative");
        chk("R3", dmem[13], 32'd5, "and result");
        chk("R3", dmem[14], 32'hFFFF_FFFD, "or result");
        chk("R1", dmem[10], 32'd0, "register cleared by reset");
        chk("R6", imem_addr, 32'h1000_0078, "backward branch to self");
        for (int i = 0; i < MEM_WORDS; i++) chk("R5", dmem[i], m_mem[i], "memory image");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule